// File: doc/BRIEF.md
# CCD Sampling Timing Sequencer

This block produces the two per-pixel control strobes that a correlated-double-sampling digitizer needs when it sits behind a CCD output. Each accepted pixel trigger starts a fixed sequence. A reference-hold level goes high to freeze the CCD reference level. After the difference signal has had time to settle, a start-convert pulse rises. The reference-hold level then drops back to acquisition and stays there until the pixel slot closes. Every duration is counted in system-clock cycles. Each one is derived, rounded up, from a nanosecond parameter and the clock period parameter. The defaults assume a 100 MHz clock.

A 2-bit bandwidth mode selects one of four timing profiles. Each profile pairs a settling time with an acquisition time: 40, 80, 150 or 300 ns for codes 0 to 3. Each profile also sets a minimum pixel period that follows from the digitizer's maximum rate for that mode: 10, 5, 3 or 1.2 MHz. The same two bits are driven out to the digitizer's bandwidth-select pins. The mode is taken only while the sequencer is idle, so the pins never change in the middle of a pixel. A trigger that arrives before the current pixel slot has run out is dropped, and a sticky overrun flag records it.

Top module: `ccd_sample_seq`

## Requirements
- R1: While reset is asserted and after it is released, ref_hold_o, start_conv_o, busy_o and overrun_o are 0 and bw_sel_o is 2'b00 (when bw_mode_i is 0).
- R2: A rising edge of pix_trig_i, seen with en_i high while idle, starts a pixel. ref_hold_o and busy_o become 1 on the same clock edge that first samples the trigger high.
- R3: ref_hold_o stays high for max(settle+1, 10) cycles: 10, 10, 16 and 31 cycles for modes 0, 1, 2 and 3. It falls only after start_conv_o has risen.
- R4: start_conv_o rises a settle count of 4, 8, 15 or 30 cycles (modes 0 to 3) after ref_hold_o rises. It rises while ref_hold_o is high and stays high for exactly 4 cycles (40 ns).
- R5: busy_o stays high for the pixel period of 15, 20, 34 or 84 cycles (modes 0 to 3). Within that period, ref_hold_o is low for at least 5, 8, 15 or 30 cycles of acquisition.
- R6: A trigger edge seen while busy_o is high, other than in the final cycle of the period, is ignored. It leaves the running pixel unchanged and sets overrun_o one cycle later. A trigger edge in the final busy cycle starts the next pixel back to back, with no overrun.
- R7: overrun_o stays set while en_i is high. One cycle with en_i low clears it.
- R8: With en_i low, trigger edges start no pixel and do not set overrun_o.
- R9: While idle, bw_sel_o follows bw_mode_i one cycle later. During a pixel, bw_sel_o holds the mode captured when the pixel started. A mode change made during a pixel takes effect at the next pixel.
- R10: A trigger held high for many cycles starts exactly one pixel and does not set overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enables acceptance of pixel triggers; low clears the overrun flag |
| pix_trig_i | input | 1 | Pixel-period trigger from the CCD clock generator, rising-edge sensitive |
| bw_mode_i | input | 2 | Bandwidth mode request, taken while idle |
| ref_hold_o | output | 1 | High holds the reference sample, low acquires |
| start_conv_o | output | 1 | Conversion start pulse, rising edge starts the digitizer |
| bw_sel_o | output | 2 | Bandwidth-select bits driven to the digitizer |
| busy_o | output | 1 | High for the whole minimum period of the current pixel |
| overrun_o | output | 1 | Sticky flag, set by a trigger arriving too early |

## Verification
The bench runs a pixel in every mode and compares the hold length, the convert offset, the convert width, the period and the acquisition span. A swapped or off-by-one profile entry would therefore show up as a wrong cycle count. It places a trigger exactly in the final busy cycle, where a design with an off-by-one window would flag a false overrun or drop a pixel. It also places one several cycles too early, where a design without the guard would restart the pixel and cut the hold short. It changes the mode in the middle of a pixel, which catches pins that move while the digitizer is sampling. It also holds the trigger high and pulses it while disabled, which exposes level-sensitive starts and overrun flags that are not gated by enable.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    localparam int unsigned SEQ_MODES = 4;

    typedef logic [1:0] bw_mode_t;

    // Convert a duration in ns to whole clock cycles, rounding up.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Hold must outlast the settle count by one cycle so the convert edge
    // lands while the reference is still held, and must meet the minimum.
    function automatic int unsigned hold_cyc(int unsigned settle_ns,
                                             int unsigned hold_min_ns,
                                             int unsigned clk_ns);
        return umax(ns_to_cyc(settle_ns, clk_ns) + 1, ns_to_cyc(hold_min_ns, clk_ns));
    endfunction

    function automatic int unsigned acq_cyc(int unsigned acq_ns,
                                            int unsigned acq_min_ns,
                                            int unsigned clk_ns);
        return umax(ns_to_cyc(acq_ns, clk_ns), ns_to_cyc(acq_min_ns, clk_ns));
    endfunction

    // Pixel slot: the longest of the rate limit, hold plus acquisition,
    // and the end of the convert pulse.
    function automatic int unsigned period_cyc(int unsigned settle_ns,
                                               int unsigned acq_ns,
                                               int unsigned rate_ns,
                                               int unsigned hold_min_ns,
                                               int unsigned acq_min_ns,
                                               int unsigned sc_ns,
                                               int unsigned clk_ns);
        int unsigned hold_c;
        int unsigned acq_c;
        int unsigned fire_c;
        hold_c = hold_cyc(settle_ns, hold_min_ns, clk_ns);
        acq_c  = acq_cyc(acq_ns, acq_min_ns, clk_ns);
        fire_c = ns_to_cyc(settle_ns, clk_ns) + ns_to_cyc(sc_ns, clk_ns);
        return umax(ns_to_cyc(rate_ns, clk_ns), umax(hold_c + acq_c, fire_c));
    endfunction

endpackage

// File: rtl/ccd_seq_profile.sv
module ccd_seq_profile
    import ccd_seq_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned SETTLE_NS [SEQ_MODES] = '{40, 80, 150, 300},
    parameter int unsigned ACQ_NS    [SEQ_MODES] = '{40, 80, 150, 300},
    parameter int unsigned RATE_NS   [SEQ_MODES] = '{100, 200, 334, 834},
    parameter int unsigned HOLD_MIN_NS = 100,
    parameter int unsigned ACQ_MIN_NS  = 50,
    parameter int unsigned SC_MIN_NS   = 40,
    parameter int unsigned CW          = 7
) (
    input  bw_mode_t        mode_i,
    output logic [CW-1:0]   hold_o,
    output logic [CW-1:0]   settle_o,
    output logic [CW-1:0]   scw_o,
    output logic [CW-1:0]   period_o
);

    logic [CW-1:0] hold_tab   [SEQ_MODES];
    logic [CW-1:0] settle_tab [SEQ_MODES];
    logic [CW-1:0] scw_tab    [SEQ_MODES];
    logic [CW-1:0] period_tab [SEQ_MODES];

    for (genvar m = 0; m < SEQ_MODES; m++) begin : g_mode
        localparam int unsigned HOLD_C   = hold_cyc(SETTLE_NS[m], HOLD_MIN_NS, CLK_NS);
        localparam int unsigned SETTLE_C = ns_to_cyc(SETTLE_NS[m], CLK_NS);
        localparam int unsigned SCW_C    = umax(ns_to_cyc(SC_MIN_NS, CLK_NS), 1);
        localparam int unsigned PERIOD_C = period_cyc(SETTLE_NS[m], ACQ_NS[m], RATE_NS[m],
                                                      HOLD_MIN_NS, ACQ_MIN_NS, SC_MIN_NS,
                                                      CLK_NS);
        assign hold_tab[m]   = CW'(HOLD_C);
        assign settle_tab[m] = CW'(SETTLE_C);
        assign scw_tab[m]    = CW'(SCW_C);
        assign period_tab[m] = CW'(PERIOD_C);
    end

    assign hold_o   = hold_tab[mode_i];
    assign settle_o = settle_tab[mode_i];
    assign scw_o    = scw_tab[mode_i];
    assign period_o = period_tab[mode_i];

endmodule

// File: rtl/ccd_seq_trig.sv
module ccd_seq_trig (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic trig_i,
    input  logic busy_i,
    input  logic last_i,
    output logic accept_o,
    output logic overrun_o
);

    typedef struct packed {
        logic trig_prev;
        logic overrun;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic        trig_edge;
    logic        slot_open;

    always_comb begin
        st_d      = st_q;
        trig_edge = trig_i & ~st_q.trig_prev;
        slot_open = ~busy_i | last_i;
        accept_o  = en_i & trig_edge & slot_open;

        st_d.trig_prev = trig_i;
        if (!en_i) begin
            st_d.overrun = 1'b0;
        end else if (trig_edge && !slot_open) begin
            st_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign overrun_o = st_q.overrun;

    // R7: once set, the flag survives every cycle in which enable stays high
    assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && st_q.overrun) |=> st_q.overrun);

    // R7: a cycle with enable low leaves the flag cleared
    assert_disable_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !st_q.overrun);

endmodule

// File: rtl/ccd_seq_phase.sv
module ccd_seq_phase
    import ccd_seq_pkg::*;
#(
    parameter int unsigned CW = 7
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            accept_i,
    input  bw_mode_t        mode_i,
    input  logic [CW-1:0]   hold_i,
    input  logic [CW-1:0]   settle_i,
    input  logic [CW-1:0]   scw_i,
    input  logic [CW-1:0]   period_i,
    output logic            ref_hold_o,
    output logic            start_conv_o,
    output bw_mode_t        bw_sel_o,
    output logic            busy_o,
    output logic            last_o
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        bw_mode_t      mode;
        logic [CW-1:0] hold;
        logic [CW-1:0] settle;
        logic [CW-1:0] scw;
        logic [CW-1:0] period;
        logic          rh;
        logic          sc;
    } phase_t;

    phase_t ph_d, ph_q;
    logic   last_cyc;

    always_comb begin
        ph_d     = ph_q;
        last_cyc = ph_q.busy && (ph_q.cnt == ph_q.period - 1'b1);

        if (accept_i) begin
            // Latch the whole profile so a mode change cannot disturb this pixel.
            ph_d.busy   = 1'b1;
            ph_d.cnt    = '0;
            ph_d.mode   = mode_i;
            ph_d.hold   = hold_i;
            ph_d.settle = settle_i;
            ph_d.scw    = scw_i;
            ph_d.period = period_i;
        end else if (ph_q.busy) begin
            if (last_cyc) begin
                ph_d.busy = 1'b0;
                ph_d.cnt  = '0;
            end else begin
                ph_d.cnt = ph_q.cnt + 1'b1;
            end
        end else begin
            ph_d.mode = mode_i;
        end

        // Strobes are registered from the next count so they align with busy.
        ph_d.rh = ph_d.busy && (ph_d.cnt < ph_d.hold);
        ph_d.sc = ph_d.busy && (ph_d.cnt >= ph_d.settle)
                            && (ph_d.cnt < ph_d.settle + ph_d.scw);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign ref_hold_o   = ph_q.rh;
    assign start_conv_o = ph_q.sc;
    assign bw_sel_o     = ph_q.mode;
    assign busy_o       = ph_q.busy;
    assign last_o       = last_cyc;

    // Run-length of the convert pulse, kept only for the width check below.
    logic [CW-1:0] sc_run_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sc_run_q <= '0;
        end else if (ph_q.sc) begin
            sc_run_q <= sc_run_q + 1'b1;
        end else begin
            sc_run_q <= '0;
        end
    end

    // R4: conversion starts only while the reference is held
    assert_sc_in_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ph_q.sc) |-> ph_q.rh);

    // R4: the convert pulse lasts exactly the latched width
    assert_sc_width_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ph_q.sc) |-> (sc_run_q == ph_q.scw));

    // R3: hold drops back to acquisition inside the pixel, after the convert edge
    assert_hold_after_sc_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ph_q.rh) |-> (ph_q.busy && (ph_q.cnt > ph_q.settle)));

    // R9: the mode pins stay frozen for the whole pixel
    assert_mode_frozen_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q.busy && $past(ph_q.busy) && !$past(accept_i)) |-> (ph_q.mode == $past(ph_q.mode)));

endmodule

// File: rtl/ccd_sample_seq.sv
module ccd_sample_seq
    import ccd_seq_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned SETTLE_NS [SEQ_MODES] = '{40, 80, 150, 300},
    parameter int unsigned ACQ_NS    [SEQ_MODES] = '{40, 80, 150, 300},
    parameter int unsigned RATE_NS   [SEQ_MODES] = '{100, 200, 334, 834},
    parameter int unsigned HOLD_MIN_NS = 100,
    parameter int unsigned ACQ_MIN_NS  = 50,
    parameter int unsigned SC_MIN_NS   = 40
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       pix_trig_i,
    input  logic [1:0] bw_mode_i,
    output logic       ref_hold_o,
    output logic       start_conv_o,
    output logic [1:0] bw_sel_o,
    output logic       busy_o,
    output logic       overrun_o
);

    function automatic int unsigned longest_pixel();
        int unsigned w;
        w = 1;
        for (int m = 0; m < SEQ_MODES; m++) begin
            w = umax(w, period_cyc(SETTLE_NS[m], ACQ_NS[m], RATE_NS[m],
                                   HOLD_MIN_NS, ACQ_MIN_NS, SC_MIN_NS, CLK_NS));
        end
        return w;
    endfunction

    localparam int unsigned CW = $clog2(longest_pixel() + 1);

    logic [CW-1:0] prof_hold;
    logic [CW-1:0] prof_settle;
    logic [CW-1:0] prof_scw;
    logic [CW-1:0] prof_period;
    logic          accept;
    logic          busy;
    logic          last;

    ccd_seq_profile #(
        .CLK_NS      (CLK_NS),
        .SETTLE_NS   (SETTLE_NS),
        .ACQ_NS      (ACQ_NS),
        .RATE_NS     (RATE_NS),
        .HOLD_MIN_NS (HOLD_MIN_NS),
        .ACQ_MIN_NS  (ACQ_MIN_NS),
        .SC_MIN_NS   (SC_MIN_NS),
        .CW          (CW)
    ) u_profile (
        .mode_i   (bw_mode_i),
        .hold_o   (prof_hold),
        .settle_o (prof_settle),
        .scw_o    (prof_scw),
        .period_o (prof_period)
    );

    ccd_seq_trig u_trig (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .trig_i    (pix_trig_i),
        .busy_i    (busy),
        .last_i    (last),
        .accept_o  (accept),
        .overrun_o (overrun_o)
    );

    ccd_seq_phase #(
        .CW (CW)
    ) u_phase (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .accept_i     (accept),
        .mode_i       (bw_mode_i),
        .hold_i       (prof_hold),
        .settle_i     (prof_settle),
        .scw_i        (prof_scw),
        .period_i     (prof_period),
        .ref_hold_o   (ref_hold_o),
        .start_conv_o (start_conv_o),
        .bw_sel_o     (bw_sel_o),
        .busy_o       (busy),
        .last_o       (last)
    );

    assign busy_o = busy;

    // R8: while disabled and idle, no pixel can begin
    assert_disabled_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !busy) |=> !busy);

endmodule

// File: tb/ccd_sample_seq_bench.sv
`timescale 1ns/1ps
module ccd_sample_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       rh;
    logic       sc;
    logic [1:0] bw;
    logic       busy;
    logic       ovr;

    ccd_sample_seq u_ccd_sample_seq (
        .clk_i        (clk),
        .rst_i        (rst),
        .en_i         (en),
        .pix_trig_i   (trig),
        .bw_mode_i    (mode),
        .ref_hold_o   (rh),
        .start_conv_o (sc),
        .bw_sel_o     (bw),
        .busy_o       (busy),
        .overrun_o    (ovr)
    );

    always #2.5 clk = ~clk;

    // Expected cycle counts per mode, taken from the requirements.
    int exp_hold   [4] = '{10, 10, 16, 31};
    int exp_settle [4] = '{4, 8, 15, 30};
    int exp_period [4] = '{15, 20, 34, 84};
    int exp_acq    [4] = '{5, 8, 15, 30};
    localparam int SC_WIDTH = 4;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];

    task automatic check(string req, int act, int expv, string what);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: measures each pixel at the ports and compares it with the queue.
    bit   in_pix = 0;
    int   k, h_cnt, sc_first, sc_cnt, b_cnt, bw_seen;
    logic rh_prev = 1'b0;

    task automatic close_pixel();
        int m;
        if (exp_q.size() == 0) begin
            check("R6 R8 R10", 1, 0, "unexpected pixel started");
        end else begin
            m = exp_q.pop_front();
            check("R3", h_cnt, exp_hold[m], "hold length");
            check("R4", sc_first, exp_settle[m], "convert offset from hold rise");
            check("R4", sc_cnt, SC_WIDTH, "convert width");
            check("R5", b_cnt, exp_period[m], "pixel period");
            check("R5", (b_cnt - h_cnt >= exp_acq[m]) ? 1 : 0, 1, "acquisition span");
            check("R9", bw_seen, m, "mode pins during pixel");
        end
        in_pix = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (in_pix && (!busy || (rh && !rh_prev))) close_pixel();
            if (rh && !rh_prev) begin
                in_pix = 1; k = 0; h_cnt = 0; sc_first = -1; sc_cnt = 0; b_cnt = 0;
                bw_seen = int'(bw);
            end
            if (in_pix) begin
                if (rh) h_cnt++;
                if (sc) begin
                    if (sc_first < 0) sc_first = k;
                    sc_cnt++;
                end
                if (busy) b_cnt++;
                k++;
            end
        end
        rh_prev = rh;
    end

    // Called at a falling edge; the trigger is sampled on the next rising edge.
    task automatic pulse();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rh, 0, "hold in reset");
        check("R1", sc, 0, "convert in reset");
        check("R1", busy, 0, "busy in reset");
        check("R1", ovr, 0, "overrun in reset");
        check("R1", bw, 0, "mode pins in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", busy, 0, "busy after reset");
        check("R1", rh, 0, "hold after reset");
        en = 1'b1;

        // One pixel in each mode
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            repeat (2) @(negedge clk);
            check("R9", bw, m, "mode pins follow while idle");
            exp_q.push_back(m);
            pulse();
            check("R2", rh, 1, "hold rises on first trigger edge");
            check("R2", busy, 1, "busy rises on first trigger edge");
            repeat (exp_period[m] + 2) @(negedge clk);
        end

        // Back-to-back pixels in mode 0, trigger in the final busy cycle
        mode = 2'd0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(0);
            pulse();
            repeat (exp_period[0] - 1) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check("R6", ovr, 0, "no overrun at exact period");

        // Early trigger in mode 1
        mode = 2'd1;
        repeat (2) @(negedge clk);
        exp_q.push_back(1);
        pulse();
        repeat (4) @(negedge clk);
        pulse();
        check("R6", ovr, 1, "early trigger sets overrun");
        check("R6", rh, 1, "running pixel keeps its hold");
        repeat (exp_period[1] + 4) @(negedge clk);
        check("R7", ovr, 1, "overrun sticky while enabled");
        en = 1'b0;
        @(negedge clk);
        check("R7", ovr, 0, "enable low clears overrun");
        en = 1'b1;

        // Mode change in the middle of a pixel
        mode = 2'd3;
        repeat (2) @(negedge clk);
        exp_q.push_back(3);
        pulse();
        repeat (5) @(negedge clk);
        mode = 2'd0;
        repeat (3) @(negedge clk);
        check("R9", bw, 3, "mode pins frozen during pixel");
        repeat (exp_period[3]) @(negedge clk);
        check("R9", bw, 0, "new mode shown once idle");
        exp_q.push_back(0);
        pulse();
        repeat (exp_period[0] + 3) @(negedge clk);

        // Disabled triggers
        en = 1'b0;
        @(negedge clk);
        pulse();
        repeat (3) @(negedge clk);
        check("R8", busy, 0, "disabled trigger starts nothing");
        check("R8", rh, 0, "disabled trigger leaves hold low");
        check("R8", ovr, 0, "disabled trigger sets no overrun");
        en = 1'b1;
        repeat (2) @(negedge clk);

        // Trigger held high: one pixel only
        mode = 2'd0;
        repeat (2) @(negedge clk);
        exp_q.push_back(0);
        trig = 1'b1;
        repeat (40) @(negedge clk);
        trig = 1'b0;
        repeat (5) @(negedge clk);
        check("R10", busy, 0, "held trigger gives a single pixel");
        check("R10", ovr, 0, "held trigger sets no overrun");
        check("R10", exp_q.size(), 0, "pixels still expected");

        finish_run();
    end

endmodule